// File: doc/BRIEF.md
# CAN Transceiver Mode Controller

This block chooses the operating state of a CAN physical-layer front end. It has three states: Active, Lowpower and Off. The choice depends on three things taken together: the two-bit chip mode code, a transceiver standby bit, and the health of the transceiver supply rail. The rail counts as healthy in one of two ways. Either the on-chip regulator is switched on and above its undervoltage threshold, or the regulator is switched off and an externally applied supply is above threshold. From the chosen state the block drives registered enables for the transmitter, the receiver, the split-pin driver and the bus wake detector, and it reports the state as a two-bit code.

The block also guards the bus against a stuck transmit input. The transmit data line passes through a synchronizer and then feeds a dominant time-out timer. If the line stays low longer than the time-out, the transmitter enable is withdrawn and the bus is released to recessive. The transmitter stays disabled until the line has been seen high again. If the transmit input is not being driven, it counts as high. The time-out length is derived from the clock rate, the slowest legal bit rate and the longest legal dominant run, so that legal traffic never trips it.

Top module: `can_xcvr_mode_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, state_o is 2'b00 (Off) and all four enables are low.
- R2: One clock after the inputs show chip mode code 2'b10 or 2'b11, standby bit 0 and a valid supply, state_o reads 2'b10 (Active).
- R3: The supply is valid when reg_on_i=1 and reg_ok_i=1, or when reg_on_i=0 and ext_ok_i=1. ext_ok_i is ignored while reg_on_i=1, and reg_ok_i is ignored while reg_on_i=0.
- R4: One clock after xcvr_stby_i=1, state_o reads 2'b01 (Lowpower) and wake_en_o is high, whatever the chip mode and supply. wake_en_o is low in every other state.
- R5: Chip mode 2'b00 or 2'b01 with the standby bit at 0, or chip mode 2'b1x with an invalid supply, gives state 2'b00 (Off). In Off, all enables are low.
- R6: rx_en_o and split_en_o are high exactly when the state is Active. State code 2'b11 never appears.
- R7: tx_en_o is high exactly when the state is Active and no dominant time-out is latched.
- R8: The time-out length is TO = (CLK_HZ/MIN_BPS)*(MAX_DOM_BITS+1) clock cycles. After TO consecutive low samples of the transmit input, tx_en_o drops at the clock edge SYNC_STAGES cycles after the last of those samples.
- R9: A single high sample restarts the timer. Low runs shorter than TO never trip it, however many of them follow each other.
- R10: Once tripped, the time-out stays latched through any mode, standby or supply change until the transmit input is seen high. The latch then clears with the same SYNC_STAGES delay.
- R11: When txd_drv_i=0 the transmit input is taken as high (recessive), whatever txd_i holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| chip_mode_i | input | 2 | Chip mode code: 00/01 low-power chip modes, 10/11 normal |
| xcvr_stby_i | input | 1 | Transceiver standby request |
| reg_on_i | input | 1 | On-chip transceiver regulator is switched on |
| reg_ok_i | input | 1 | On-chip regulator output above undervoltage threshold |
| ext_ok_i | input | 1 | Externally applied transceiver supply above threshold |
| txd_i | input | 1 | Transmit data from the protocol controller (low = dominant) |
| txd_drv_i | input | 1 | Transmit input is actively driven; 0 means floating |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| split_en_o | output | 1 | Split-pin driver enable (tri-state when low) |
| wake_en_o | output | 1 | Bus wake detector enable |
| state_o | output | 2 | Current state: 00 Off, 01 Lowpower, 10 Active |

## Verification
The mode decision and the dominant time-out both act on tx_en_o, and they can change it on the same clock edge. The time-out can trip on the edge where the state leaves Active, and the latch can clear on the edge where the state returns to Active. A directed case lines up a chip mode change with the exact trip edge. Random stimulus mixes long and short low runs on the transmit input with frequent changes of mode, standby and supply, so that such collisions recur many times. A bench model predicts every output on every cycle: it takes the state from the three mode inputs and the trip from a delayed count of the low run, and judges tx_en_o as the AND of the two.

// File: rtl/can_xcvr_pkg.sv
package can_xcvr_pkg;
  typedef enum logic [1:0] {
    XS_OFF    = 2'b00,
    XS_LOWPWR = 2'b01,
    XS_ACTIVE = 2'b10
  } xcvr_state_t;
endpackage

// File: rtl/cxm_supply_qual.sv
module cxm_supply_qual (
  input  logic reg_on_i,
  input  logic reg_ok_i,
  input  logic ext_ok_i,
  output logic sup_ok_o
);
  // Regulator path when enabled, external path when disabled
  always_comb begin
    if (reg_on_i) sup_ok_o = reg_ok_i;
    else          sup_ok_o = ext_ok_i;
  end
endmodule

// File: rtl/cxm_txd_sync.sv
module cxm_txd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic txd_i,
  input  logic txd_drv_i,
  output logic txd_s_o
);
  logic [STAGES-1:0] chain_q;
  logic              txd_eff;

  // An undriven input reads as recessive
  assign txd_eff = txd_i | ~txd_drv_i;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (rst_i) chain_q[0] <= 1'b1;
          else       chain_q[0] <= txd_eff;
        end
      end else begin : g_next
        always_ff @(posedge clk_i) begin
          if (rst_i) chain_q[g] <= 1'b1;
          else       chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign txd_s_o = chain_q[STAGES-1];
endmodule

// File: rtl/cxm_dom_timer.sv
module cxm_dom_timer #(
  parameter int TO_CYC = 72000,
  parameter int CNT_W  = $clog2(TO_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic txd_s_i,
  output logic trip_d_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TO_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             trip_q, trip_d;

  always_comb begin
    cnt_d  = cnt_q;
    trip_d = trip_q;
    if (txd_s_i) begin
      cnt_d  = '0;
      trip_d = 1'b0;
    end else if (!trip_q) begin
      if (cnt_q == LAST) trip_d = 1'b1;
      else               cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      trip_q <= trip_d;
    end
  end

  assign trip_d_o = trip_d;
endmodule

// File: rtl/cxm_mode_fsm.sv
module cxm_mode_fsm
  import can_xcvr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [1:0] chip_mode_i,
  input  logic       stby_i,
  input  logic       sup_ok_i,
  input  logic       trip_d_i,
  output logic       tx_en_o,
  output logic       rx_en_o,
  output logic       split_en_o,
  output logic       wake_en_o,
  output logic [1:0] state_o
);
  xcvr_state_t state_q, state_d;
  logic        tx_q, rx_q, split_q, wake_q;

  always_comb begin
    if (stby_i)                        state_d = XS_LOWPWR;
    else if (chip_mode_i[1] && sup_ok_i) state_d = XS_ACTIVE;
    else                               state_d = XS_OFF;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= XS_OFF;
      tx_q    <= 1'b0;
      rx_q    <= 1'b0;
      split_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tx_q    <= (state_d == XS_ACTIVE) && !trip_d_i;
      rx_q    <= (state_d == XS_ACTIVE);
      split_q <= (state_d == XS_ACTIVE);
      wake_q  <= (state_d == XS_LOWPWR);
    end
  end

  assign tx_en_o    = tx_q;
  assign rx_en_o    = rx_q;
  assign split_en_o = split_q;
  assign wake_en_o  = wake_q;
  assign state_o    = state_q;
endmodule

// File: rtl/can_xcvr_mode_ctrl.sv
module can_xcvr_mode_ctrl #(
  parameter int CLK_HZ       = 40_000_000,
  parameter int MIN_BPS      = 10_000,
  parameter int MAX_DOM_BITS = 17,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [1:0] chip_mode_i,
  input  logic       xcvr_stby_i,
  input  logic       reg_on_i,
  input  logic       reg_ok_i,
  input  logic       ext_ok_i,
  input  logic       txd_i,
  input  logic       txd_drv_i,
  output logic       tx_en_o,
  output logic       rx_en_o,
  output logic       split_en_o,
  output logic       wake_en_o,
  output logic [1:0] state_o
);
  localparam int BIT_CYC = CLK_HZ / MIN_BPS;
  localparam int TO_CYC  = BIT_CYC * (MAX_DOM_BITS + 1);
  localparam int CNT_W   = $clog2(TO_CYC + 1);

  logic sup_ok, txd_s, trip_d;

  cxm_supply_qual u_sup (
    .reg_on_i (reg_on_i),
    .reg_ok_i (reg_ok_i),
    .ext_ok_i (ext_ok_i),
    .sup_ok_o (sup_ok)
  );

  cxm_txd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .txd_i     (txd_i),
    .txd_drv_i (txd_drv_i),
    .txd_s_o   (txd_s)
  );

  cxm_dom_timer #(.TO_CYC(TO_CYC), .CNT_W(CNT_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .txd_s_i  (txd_s),
    .trip_d_o (trip_d)
  );

  cxm_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .chip_mode_i (chip_mode_i),
    .stby_i      (xcvr_stby_i),
    .sup_ok_i    (sup_ok),
    .trip_d_i    (trip_d),
    .tx_en_o     (tx_en_o),
    .rx_en_o     (rx_en_o),
    .split_en_o  (split_en_o),
    .wake_en_o   (wake_en_o),
    .state_o     (state_o)
  );
endmodule

// File: rtl/can_xcvr_mode_chk.sv
module can_xcvr_mode_chk
  import can_xcvr_pkg::*;
#(
  parameter int TO_CYC      = 72000,
  parameter int SYNC_STAGES = 2
) (
  input logic       clk_i,
  input logic       rst_i,
  input logic [1:0] chip_mode_i,
  input logic       xcvr_stby_i,
  input logic       reg_on_i,
  input logic       reg_ok_i,
  input logic       ext_ok_i,
  input logic       txd_i,
  input logic       txd_drv_i,
  input logic       tx_en_o,
  input logic       rx_en_o,
  input logic       split_en_o,
  input logic       wake_en_o,
  input logic [1:0] state_o
);
  localparam int LIM = TO_CYC + SYNC_STAGES;
  localparam int RW  = $clog2(LIM + 1);

  logic [RW-1:0] low_run_q;
  logic          sup_valid;

  assign sup_valid = reg_on_i ? reg_ok_i : ext_ok_i;

  always_ff @(posedge clk_i) begin
    if (rst_i || txd_i || !txd_drv_i) low_run_q <= '0;
    else if (low_run_q != RW'(LIM))   low_run_q <= low_run_q + 1'b1;
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk_i)
    $past(rst_i) |-> (state_o == XS_OFF && !tx_en_o && !rx_en_o && !split_en_o && !wake_en_o));

  // R4
  stby_lowpwr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(!rst_i) && $past(xcvr_stby_i)) |-> (state_o == XS_LOWPWR && wake_en_o));

  // R2
  enter_active_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(!rst_i) && $past(!xcvr_stby_i && chip_mode_i[1] && sup_valid)) |-> (state_o == XS_ACTIVE));

  // R5
  off_state_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(!rst_i) && $past(!xcvr_stby_i && !(chip_mode_i[1] && sup_valid))) |-> (state_o == XS_OFF && !wake_en_o && !rx_en_o));

  // R6
  split_rx_active_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (split_en_o == (state_o == XS_ACTIVE)) && (rx_en_o == split_en_o) && (state_o != 2'b11));

  // R7
  tx_needs_active_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    tx_en_o |-> (state_o == XS_ACTIVE));

  // R8
  dom_timeout_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (low_run_q == RW'(LIM)) |-> !tx_en_o);
endmodule

bind can_xcvr_mode_ctrl can_xcvr_mode_chk #(.TO_CYC(TO_CYC), .SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/can_xcvr_mode_ctrl_bench.sv
module can_xcvr_mode_ctrl_bench;
  localparam int CLK_HZ = 200_000;
  localparam int MIN_BPS = 10_000;
  localparam int MAX_DOM_BITS = 17;
  localparam int S = 2;
  localparam int TO = (CLK_HZ / MIN_BPS) * (MAX_DOM_BITS + 1);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       stby = 1'b0, ron = 1'b1, rok = 1'b1, eok = 1'b0;
  logic       txd = 1'b1, tdrv = 1'b1;
  logic       tx_en, rx_en, split_en, wake_en;
  logic [1:0] state;

  int checks = 0, errors = 0;
  int lowrun = 0;
  int pipe [0:S];
  logic [1:0] exp_st;
  logic exp_tx;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_xcvr_mode_ctrl #(.CLK_HZ(CLK_HZ), .MIN_BPS(MIN_BPS), .MAX_DOM_BITS(MAX_DOM_BITS),
                       .SYNC_STAGES(S)) u_can_xcvr_mode_ctrl (
    .clk_i(clk), .rst_i(rst), .chip_mode_i(mode), .xcvr_stby_i(stby),
    .reg_on_i(ron), .reg_ok_i(rok), .ext_ok_i(eok), .txd_i(txd), .txd_drv_i(tdrv),
    .tx_en_o(tx_en), .rx_en_o(rx_en), .split_en_o(split_en), .wake_en_o(wake_en),
    .state_o(state));

  function automatic logic [1:0] f_state(logic [1:0] m, logic sb, logic on, logic ok, logic ek);
    logic sv;
    sv = on ? ok : ek;
    if (sb) return 2'b01;
    if (m[1] && sv) return 2'b10;
    return 2'b00;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // advance one edge, update model with the inputs seen at that edge, compare
  task automatic step(string req);
    logic teff;
    @(posedge clk);
    teff = txd | ~tdrv;
    if (rst) begin
      lowrun = 0;
      for (int k = 0; k <= S; k++) pipe[k] = 0;
      exp_st = 2'b00;
      exp_tx = 1'b0;
    end else begin
      lowrun = teff ? 0 : ((lowrun < TO) ? lowrun + 1 : TO);
      for (int k = S; k > 0; k--) pipe[k] = pipe[k-1];
      pipe[0] = lowrun;
      exp_st = f_state(mode, stby, ron, rok, eok);
      exp_tx = (exp_st == 2'b10) && (pipe[S] < TO);
    end
    @(negedge clk);
    chk({req, " state"}, {6'd0, state}, {6'd0, exp_st});
    chk({req, " tx_en R7"}, {7'd0, tx_en}, {7'd0, exp_tx});
    chk({req, " rx_en R6"}, {7'd0, rx_en}, {7'd0, exp_st == 2'b10});
    chk({req, " split_en R6"}, {7'd0, split_en}, {7'd0, exp_st == 2'b10});
    chk({req, " wake_en R4"}, {7'd0, wake_en}, {7'd0, exp_st == 2'b01});
  endtask

  task automatic steps(string req, int n);
    for (int i = 0; i < n; i++) step(req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    steps("R1", 3);
    rst = 1'b0;
    mode = 2'b10;
    step("R1");
    // R2: entry to Active, both normal codes
    steps("R2", 2);
    mode = 2'b11;
    steps("R2", 2);
    // R3: regulator path and external path
    rok = 1'b0; eok = 1'b1;
    steps("R3", 2);
    ron = 1'b0;
    steps("R3", 2);
    eok = 1'b0; rok = 1'b1;
    steps("R3", 2);
    eok = 1'b1;
    steps("R3", 2);
    // R4: standby bit wins in every mode
    stby = 1'b1;
    for (int m = 0; m < 4; m++) begin
      mode = m[1:0];
      steps("R4", 2);
    end
    // R5: low-power chip modes with standby clear
    stby = 1'b0; mode = 2'b01;
    steps("R5", 2);
    mode = 2'b00;
    steps("R5", 2);
    // R8: exact trip edge
    mode = 2'b10; ron = 1'b1; rok = 1'b1;
    steps("R8", 3);
    txd = 1'b0;
    steps("R8", TO + S - 1);
    chk("R8 tx_en before trip", {7'd0, tx_en}, 8'd1);
    step("R8");
    chk("R8 tx_en after trip", {7'd0, tx_en}, 8'd0);
    // R10: latch survives mode changes while txd stays low
    mode = 2'b00; steps("R10", 3);
    stby = 1'b1; steps("R10", 3);
    stby = 1'b0; mode = 2'b11; steps("R10", 5);
    chk("R10 latched", {7'd0, tx_en}, 8'd0);
    txd = 1'b1; steps("R10", S + 2);
    chk("R10 released", {7'd0, tx_en}, 8'd1);
    // R9: short low runs never accumulate
    for (int r = 0; r < 4; r++) begin
      txd = 1'b0; steps("R9", TO - 1);
      txd = 1'b1; step("R9");
    end
    steps("R9", S + 1);
    chk("R9 no trip", {7'd0, tx_en}, 8'd1);
    // R11: floating input counts as recessive
    txd = 1'b0; tdrv = 1'b0;
    steps("R11", TO + S + 4);
    chk("R11 float", {7'd0, tx_en}, 8'd1);
    tdrv = 1'b1;
    // same-edge collision: trip edge coincides with leaving Active
    steps("R8", TO + S - 1);
    mode = 2'b00;
    step("R8");
    mode = 2'b10;
    steps("R10", 4);
    txd = 1'b1;
    steps("R10", S + 2);
    // random mix
    for (int seg = 0; seg < 300; seg++) begin
      int len;
      txd = $urandom_range(0, 1);
      tdrv = ($urandom_range(0, 9) != 0);
      len = (txd == 1'b0 && $urandom_range(0, 2) == 0) ? $urandom_range(TO - 3, TO + 40)
                                                      : $urandom_range(1, 60);
      for (int i = 0; i < len; i++) begin
        if ($urandom_range(0, 39) == 0) mode = 2'($urandom_range(0, 3));
        if ($urandom_range(0, 59) == 0) stby = $urandom_range(0, 1);
        if ($urandom_range(0, 49) == 0) begin
          ron = $urandom_range(0, 1); rok = $urandom_range(0, 1); eok = $urandom_range(0, 1);
        end
        step("R2 R3 R5 random");
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule